// File: doc/BRIEF.md
# Tag-Based Operand Capture Pool

This block is a small pool of waiting stations that sits between an in-order issue stage and one functional unit. Each issued instruction takes a free station. For each source register the block looks up its own rename map. If no station is pending on that register, the value that came with the issue is stored. If one is pending, the number (tag) of that producing station is stored and the operand is marked missing.

Results come back on a single broadcast bus as a tag plus a value. Every waiting station whose missing operand carries that tag takes the value in the same cycle. A station whose operands are all present may be sent to the functional unit. When several stations qualify, the one issued earliest goes first, and at most one goes per cycle. A station stays allocated from issue until the result carrying its own tag is broadcast, so a tag is never reused while it can still appear on the bus.

The rename map records, for each architectural register, the tag of its newest pending writer. A broadcast result is written back to the register file only when its tag is still that newest writer.

Top module: `opcap_pool`

## Requirements
- R1: After reset every station is free and every register is unmapped: `iss_ready_o` is 1, `disp_valid_o` is 0, and the first issued operands take the values supplied with the issue.
- R2: `iss_ready_o` is 0 exactly when all stations are allocated; an issue presented then is ignored and changes no later output.
- R3: At issue, a source whose register is unmapped is stored with the supplied value; a source mapped to a pending tag waits for that tag, and the supplied value is discarded.
- R4: When `res_valid_i` is 1, every waiting station with a missing operand whose tag equals `res_tag_i` stores `res_data_i`, and can be dispatched from the next cycle.
- R5: A source mapped to tag T is filled with `res_data_i` if T is broadcast in the same cycle as the issue.
- R6: A station is offered for dispatch only while both of its operands are present and it has not yet been dispatched.
- R7: `disp_valid_o` presents the earliest-issued eligible station (its tag on `disp_tag_o`, opcode and both operands). It is taken only in a cycle with `disp_grant_i` 1, and at most one station is taken per cycle.
- R8: Issue maps the destination register to the new station's tag. A broadcast raises `wb_valid_o` combinationally in the same cycle, with `wb_reg_o` set to that station's destination and `wb_data_o` to `res_data_i`, only while the map still holds that tag; the map entry is then cleared.
- R9: If an issue writing register D coincides with a broadcast from D's older writer, no writeback happens and D maps to the new tag.
- R10: A station is freed only by the broadcast of its own tag, not at dispatch. A new issue takes the lowest-numbered free station, and its tag is that station number (0 to 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | 4 | Opcode of issued instruction |
| iss_dst_i | input | 2 | Destination register |
| iss_src_a_i | input | 2 | First source register |
| iss_src_b_i | input | 2 | Second source register |
| iss_val_a_i | input | 16 | Register-file value of first source |
| iss_val_b_i | input | 16 | Register-file value of second source |
| iss_ready_o | output | 1 | A station is free (issue accepted) |
| res_valid_i | input | 1 | Result broadcast valid |
| res_tag_i | input | 3 | Tag of broadcasting station |
| res_data_i | input | 16 | Broadcast result value |
| disp_valid_o | output | 1 | An eligible station is presented |
| disp_grant_i | input | 1 | Functional unit takes the presented station |
| disp_op_o | output | 4 | Opcode of presented station |
| disp_tag_o | output | 3 | Tag of presented station |
| disp_a_o | output | 16 | First operand |
| disp_b_o | output | 16 | Second operand |
| wb_valid_o | output | 1 | Register-file write enable |
| wb_reg_o | output | 2 | Register-file write address |
| wb_data_o | output | 16 | Register-file write data |

## Verification
The assertions assume that a tag is broadcast only while its station has been dispatched and is still awaiting its result, that at most one result arrives per cycle, and that `res_tag_i` always names an existing station. The stimulus meets these assumptions by broadcasting only tags that the bench's own model holds as dispatched and not yet completed. Directed phases first set up same-cycle forwarding and the superseded-writer case. A long random phase then mixes issue, grant and broadcast while the pool runs full and stations are reused.

// File: rtl/opcap_pkg.sv
package opcap_pkg;
  parameter int DW   = 16;
  parameter int OPW  = 4;
  parameter int NREG = 4;
  parameter int NRS  = 6;
  localparam int RW  = $clog2(NREG);
  localparam int TW  = $clog2(NRS);

  typedef struct packed {
    logic          rdy;
    logic [TW-1:0] tag;
    logic [DW-1:0] val;
  } opnd_t;
endpackage

// File: rtl/opcap_entry.sv
module opcap_entry
  import opcap_pkg::*;
#(
  parameter int MY_TAG = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_i,
  input  logic [OPW-1:0] op_i,
  input  logic [RW-1:0]  dst_i,
  input  opnd_t          a_i,
  input  opnd_t          b_i,
  input  logic           res_v_i,
  input  logic [TW-1:0]  res_tag_i,
  input  logic [DW-1:0]  res_data_i,
  input  logic           take_i,
  output logic           busy_o,
  output logic           ready_o,
  output logic [OPW-1:0] op_o,
  output logic [RW-1:0]  dst_o,
  output logic [DW-1:0]  a_o,
  output logic [DW-1:0]  b_o
);
  logic           busy_q, busy_d, exec_q, exec_d;
  logic [OPW-1:0] op_q, op_d;
  logic [RW-1:0]  dst_q, dst_d;
  opnd_t          a_q, a_d, b_q, b_d;
  logic           hit_own, waiting, fld_en;

  assign hit_own = res_v_i && (res_tag_i == TW'(MY_TAG));
  assign waiting = busy_q && !exec_q;
  assign fld_en  = alloc_i || waiting;

  always_comb begin
    busy_d = busy_q;
    exec_d = exec_q;
    op_d   = op_q;
    dst_d  = dst_q;
    a_d    = a_q;
    b_d    = b_q;
    if (alloc_i) begin
      busy_d = 1'b1;
      exec_d = 1'b0;
      op_d   = op_i;
      dst_d  = dst_i;
      a_d    = a_i;
      b_d    = b_i;
    end else begin
      if (waiting && !a_q.rdy && res_v_i && res_tag_i == a_q.tag) begin
        a_d.rdy = 1'b1;
        a_d.val = res_data_i;
      end
      if (waiting && !b_q.rdy && res_v_i && res_tag_i == b_q.tag) begin
        b_d.rdy = 1'b1;
        b_d.val = res_data_i;
      end
      if (take_i) exec_d = 1'b1;
      if (busy_q && exec_q && hit_own) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      exec_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      exec_q <= exec_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fld_en) begin
      op_q  <= op_d;
      dst_q <= dst_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = waiting && a_q.rdy && b_q.rdy;
  assign op_o    = op_q;
  assign dst_o   = dst_q;
  assign a_o     = a_q.val;
  assign b_o     = b_q.val;

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !busy_q); // R2
  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !a_q.rdy && res_v_i && res_tag_i == a_q.tag)
      |=> (a_q.rdy && a_q.val == $past(res_data_i))); // R4
  AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !b_q.rdy && res_v_i && res_tag_i == b_q.tag)
      |=> (b_q.rdy && b_q.val == $past(res_data_i))); // R4
  AST_TAKE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> ready_o); // R6
  AST_FREE_ON_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && exec_q && hit_own) |=> !busy_q); // R10
  AST_RESULT_AFTER_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_own && busy_q) |-> exec_q); // R10
endmodule

// File: rtl/opcap_rename.sv
module opcap_rename
  import opcap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en_i,
  input  logic [RW-1:0] set_reg_i,
  input  logic [TW-1:0] set_tag_i,
  input  logic          clr_en_i,
  input  logic [RW-1:0] clr_reg_i,
  input  logic [RW-1:0] qa_reg_i,
  output logic          qa_v_o,
  output logic [TW-1:0] qa_tag_o,
  input  logic [RW-1:0] qb_reg_i,
  output logic          qb_v_o,
  output logic [TW-1:0] qb_tag_o,
  input  logic [RW-1:0] qw_reg_i,
  output logic          qw_v_o,
  output logic [TW-1:0] qw_tag_o
);
  logic [NREG-1:0] v_q, v_d;
  logic [TW-1:0]   tag_q [NREG];

  always_comb begin
    v_d = v_q;
    if (clr_en_i) v_d[clr_reg_i] = 1'b0;
    if (set_en_i) v_d[set_reg_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (set_en_i) tag_q[set_reg_i] <= set_tag_i;
  end

  assign qa_v_o   = v_q[qa_reg_i];
  assign qa_tag_o = tag_q[qa_reg_i];
  assign qb_v_o   = v_q[qb_reg_i];
  assign qb_tag_o = tag_q[qb_reg_i];
  assign qw_v_o   = v_q[qw_reg_i];
  assign qw_tag_o = tag_q[qw_reg_i];

  AST_RENAME_TAKES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |=> (v_q[$past(set_reg_i)] && tag_q[$past(set_reg_i)] == $past(set_tag_i))); // R8
endmodule

// File: rtl/opcap_age_pick.sv
module opcap_age_pick #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // older_q[j][i] set: station j was issued before station i
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];

  always_comb begin
    for (int j = 0; j < N; j++) older_d[j] = older_q[j];
    for (int k = 0; k < N; k++) begin
      if (alloc_i[k]) begin
        older_d[k] = '0;
        for (int j = 0; j < N; j++) if (j != k) older_d[j][k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) older_q[j] <= '0;
    end else if (|alloc_i) begin
      for (int j = 0; j < N; j++) older_q[j] <= older_d[j];
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_pick
    logic [N-1:0] blockers;
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign blockers[gj] = req_i[gj] && older_q[gj][gi];
    end
    assign gnt_o[gi] = req_i[gi] && !(|blockers);
  end

  AST_PICK_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R7
  AST_PICK_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (|gnt_o)); // R7
endmodule

// File: rtl/opcap_pool.sv
module opcap_pool
  import opcap_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid_i,
  input  logic [OPW-1:0] iss_op_i,
  input  logic [RW-1:0]  iss_dst_i,
  input  logic [RW-1:0]  iss_src_a_i,
  input  logic [RW-1:0]  iss_src_b_i,
  input  logic [DW-1:0]  iss_val_a_i,
  input  logic [DW-1:0]  iss_val_b_i,
  output logic           iss_ready_o,
  input  logic           res_valid_i,
  input  logic [TW-1:0]  res_tag_i,
  input  logic [DW-1:0]  res_data_i,
  output logic           disp_valid_o,
  input  logic           disp_grant_i,
  output logic [OPW-1:0] disp_op_o,
  output logic [TW-1:0]  disp_tag_o,
  output logic [DW-1:0]  disp_a_o,
  output logic [DW-1:0]  disp_b_o,
  output logic           wb_valid_o,
  output logic [RW-1:0]  wb_reg_o,
  output logic [DW-1:0]  wb_data_o
);
  logic [NRS-1:0] busy, ready, gnt, take, free_oh, alloc;
  logic [TW-1:0]  free_tag;
  logic [OPW-1:0] ent_op  [NRS];
  logic [RW-1:0]  ent_dst [NRS];
  logic [DW-1:0]  ent_a   [NRS];
  logic [DW-1:0]  ent_b   [NRS];
  logic           fire;
  logic           qa_v, qb_v, qw_v;
  logic [TW-1:0]  qa_tag, qb_tag, qw_tag;
  opnd_t          src_a, src_b;
  logic [RW-1:0]  res_dst;

  // lowest-numbered free station
  always_comb begin
    free_oh  = '0;
    free_tag = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
        free_tag   = TW'(i);
      end
    end
  end

  assign iss_ready_o = !(&busy);
  assign fire        = iss_valid_i && iss_ready_o;
  assign alloc       = fire ? free_oh : '0;

  always_comb begin
    src_a.tag = qa_tag;
    src_b.tag = qb_tag;
    if (!qa_v) begin
      src_a.rdy = 1'b1; src_a.val = iss_val_a_i;
    end else if (res_valid_i && res_tag_i == qa_tag) begin
      src_a.rdy = 1'b1; src_a.val = res_data_i;
    end else begin
      src_a.rdy = 1'b0; src_a.val = '0;
    end
    if (!qb_v) begin
      src_b.rdy = 1'b1; src_b.val = iss_val_b_i;
    end else if (res_valid_i && res_tag_i == qb_tag) begin
      src_b.rdy = 1'b1; src_b.val = res_data_i;
    end else begin
      src_b.rdy = 1'b0; src_b.val = '0;
    end
  end

  for (genvar g = 0; g < NRS; g++) begin : g_ent
    opcap_entry #(.MY_TAG(g)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (alloc[g]),
      .op_i      (iss_op_i),
      .dst_i     (iss_dst_i),
      .a_i       (src_a),
      .b_i       (src_b),
      .res_v_i   (res_valid_i),
      .res_tag_i (res_tag_i),
      .res_data_i(res_data_i),
      .take_i    (take[g]),
      .busy_o    (busy[g]),
      .ready_o   (ready[g]),
      .op_o      (ent_op[g]),
      .dst_o     (ent_dst[g]),
      .a_o       (ent_a[g]),
      .b_o       (ent_b[g])
    );
  end

  opcap_age_pick #(.N(NRS)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .alloc_i(alloc),
    .req_i  (ready),
    .gnt_o  (gnt)
  );

  assign take = disp_grant_i ? gnt : '0;

  always_comb begin
    disp_op_o  = '0;
    disp_tag_o = '0;
    disp_a_o   = '0;
    disp_b_o   = '0;
    res_dst    = '0;
    for (int i = 0; i < NRS; i++) begin
      if (gnt[i]) begin
        disp_op_o  = ent_op[i];
        disp_tag_o = TW'(i);
        disp_a_o   = ent_a[i];
        disp_b_o   = ent_b[i];
      end
      if (res_tag_i == TW'(i)) res_dst = ent_dst[i];
    end
  end
  assign disp_valid_o = |gnt;

  assign wb_valid_o = res_valid_i && qw_v && (qw_tag == res_tag_i)
                      && !(fire && iss_dst_i == res_dst);
  assign wb_reg_o   = res_dst;
  assign wb_data_o  = res_data_i;

  opcap_rename u_ren (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (fire),
    .set_reg_i(iss_dst_i),
    .set_tag_i(free_tag),
    .clr_en_i (wb_valid_o),
    .clr_reg_i(res_dst),
    .qa_reg_i (iss_src_a_i),
    .qa_v_o   (qa_v),
    .qa_tag_o (qa_tag),
    .qb_reg_i (iss_src_b_i),
    .qb_v_o   (qb_v),
    .qb_tag_o (qb_tag),
    .qw_reg_i (res_dst),
    .qw_v_o   (qw_v),
    .qw_tag_o (qw_tag)
  );

  AST_ONE_TAKE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R7
endmodule

// File: tb/opcap_pool_bench.sv
module opcap_pool_bench;
  import opcap_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           iss_valid, iss_ready, res_valid, disp_valid, disp_grant, wb_valid;
  logic [OPW-1:0] iss_op, disp_op;
  logic [RW-1:0]  iss_dst, iss_sa, iss_sb, wb_reg;
  logic [DW-1:0]  iss_va, iss_vb, res_data, disp_a, disp_b, wb_data;
  logic [TW-1:0]  res_tag, disp_tag;

  opcap_pool u_opcap_pool (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op), .iss_dst_i(iss_dst),
    .iss_src_a_i(iss_sa), .iss_src_b_i(iss_sb),
    .iss_val_a_i(iss_va), .iss_val_b_i(iss_vb), .iss_ready_o(iss_ready),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_data_i(res_data),
    .disp_valid_o(disp_valid), .disp_grant_i(disp_grant), .disp_op_o(disp_op),
    .disp_tag_o(disp_tag), .disp_a_o(disp_a), .disp_b_o(disp_b),
    .wb_valid_o(wb_valid), .wb_reg_o(wb_reg), .wb_data_o(wb_data)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  string ph = "R1";

  // behavioural model
  int m_busy[NRS], m_exec[NRS], m_op[NRS], m_dst[NRS], m_seq[NRS];
  int m_ar[NRS], m_at[NRS], m_av[NRS], m_br[NRS], m_bt[NRS], m_bv[NRS];
  int m_rv[NREG], m_rt[NREG];
  int seqc = 0;
  int e_rdy, e_free, e_dv, e_dt, e_wb, e_wr;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NRS; i++) begin m_busy[i] = 0; m_exec[i] = 0; end
    for (int r = 0; r < NREG; r++) m_rv[r] = 0;
  endtask

  task automatic exp_calc();
    int best;
    e_rdy = 0; e_free = -1; e_dv = 0; e_dt = 0; best = 0;
    for (int i = NRS - 1; i >= 0; i--) if (!m_busy[i]) begin e_rdy = 1; e_free = i; end
    for (int i = 0; i < NRS; i++)
      if (m_busy[i] && !m_exec[i] && m_ar[i] && m_br[i] && (!e_dv || m_seq[i] < best)) begin
        e_dv = 1; e_dt = i; best = m_seq[i];
      end
    e_wb = 0; e_wr = 0;
    if (res_valid) begin
      e_wr = m_dst[res_tag];
      e_wb = (m_rv[e_wr] && m_rt[e_wr] == int'(res_tag) &&
              !(iss_valid && e_rdy && int'(iss_dst) == e_wr)) ? 1 : 0;
    end
  endtask

  task automatic compare();
    exp_calc();
    chk("R2", "iss_ready", int'(iss_ready), e_rdy);
    chk("R7", "disp_valid", int'(disp_valid), e_dv);
    if (e_dv) begin
      chk("R7", "disp_tag", int'(disp_tag), e_dt);
      chk("R7", "disp_op", int'(disp_op), m_op[e_dt]);
      chk("R4", "disp_a", int'(disp_a), m_av[e_dt]);
      chk("R4", "disp_b", int'(disp_b), m_bv[e_dt]);
    end
    chk("R8", "wb_valid", int'(wb_valid), e_wb);
    if (e_wb) begin
      chk("R8", "wb_reg", int'(wb_reg), e_wr);
      chk("R8", "wb_data", int'(wb_data), int'(res_data));
    end
  endtask

  task automatic model_update();
    int ar, at, av, br, bt, bv;
    // source lookup on pre-edge map, with same-cycle forwarding (R5)
    ar = 1; at = 0; av = int'(iss_va);
    if (m_rv[iss_sa]) begin
      at = m_rt[iss_sa];
      if (res_valid && int'(res_tag) == at) av = int'(res_data); else begin ar = 0; av = 0; end
    end
    br = 1; bt = 0; bv = int'(iss_vb);
    if (m_rv[iss_sb]) begin
      bt = m_rt[iss_sb];
      if (res_valid && int'(res_tag) == bt) bv = int'(res_data); else begin br = 0; bv = 0; end
    end
    for (int i = 0; i < NRS; i++) if (m_busy[i] && !m_exec[i] && res_valid) begin
      if (!m_ar[i] && m_at[i] == int'(res_tag)) begin m_ar[i] = 1; m_av[i] = int'(res_data); end
      if (!m_br[i] && m_bt[i] == int'(res_tag)) begin m_br[i] = 1; m_bv[i] = int'(res_data); end
    end
    if (res_valid && m_busy[res_tag] && m_exec[res_tag]) m_busy[res_tag] = 0;
    if (e_dv && disp_grant) m_exec[e_dt] = 1;
    if (e_wb) m_rv[e_wr] = 0;
    if (iss_valid && e_rdy) begin
      m_busy[e_free] = 1; m_exec[e_free] = 0; m_op[e_free] = int'(iss_op);
      m_dst[e_free] = int'(iss_dst); m_seq[e_free] = seqc; seqc++;
      m_ar[e_free] = ar; m_at[e_free] = at; m_av[e_free] = av;
      m_br[e_free] = br; m_bt[e_free] = bt; m_bv[e_free] = bv;
      m_rv[iss_dst] = 1; m_rt[iss_dst] = e_free;
    end
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_in();
    iss_valid = 0; res_valid = 0; disp_grant = 0;
    iss_op = 0; iss_dst = 0; iss_sa = 0; iss_sb = 0; iss_va = 0; iss_vb = 0;
    res_tag = 0; res_data = 0;
  endtask

  task automatic issue(input int op, input int d, input int a, input int b, input int va, input int vb);
    iss_valid = 1; iss_op = OPW'(op); iss_dst = RW'(d); iss_sa = RW'(a); iss_sb = RW'(b);
    iss_va = DW'(va); iss_vb = DW'(vb);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      summary();
    end
  end

  initial begin
    idle_in();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ph = "R1";
    chk("R1", "iss_ready after reset", int'(iss_ready), 1);
    chk("R1", "disp_valid after reset", int'(disp_valid), 0);
    step();

    // R3: unmapped sources take supplied values
    ph = "R3";
    issue(1, 1, 2, 3, 'h10, 'h20); step(); idle_in();
    chk("R3", "disp_a copied", int'(disp_a), 'h10);
    chk("R3", "disp_b copied", int'(disp_b), 'h20);
    // second issue reads r1 (mapped to tag 0): supplied value discarded
    issue(2, 2, 1, 3, 'h99, 'h30); step(); idle_in();
    chk("R6", "waiting entry not offered", int'(disp_tag), 0);
    ph = "R6";
    disp_grant = 1; step(); idle_in();
    chk("R6", "no eligible after take", int'(disp_valid), 0);

    // R4: broadcast tag 0 fills station 1, R8 writeback r1
    ph = "R4";
    res_valid = 1; res_tag = 0; res_data = 'h55; #1;
    chk("R8", "wb newest writer", int'(wb_valid), 1);
    step(); idle_in();
    chk("R4", "captured operand", int'(disp_a), 'h55);
    chk("R4", "captured tag", int'(disp_tag), 1);

    // R5: dispatch station 1, then issue reading r2 as tag 1 broadcasts
    ph = "R5";
    disp_grant = 1; step(); idle_in();
    issue(3, 3, 2, 0, 0, 7);
    res_valid = 1; res_tag = 1; res_data = 'h77; step(); idle_in();
    chk("R10", "reuse lowest free tag", int'(disp_tag), 0);
    chk("R5", "forwarded operand", int'(disp_a), 'h77);

    // R9: newer writer of r3 while older writer of r3 broadcasts
    ph = "R9";
    disp_grant = 1; step(); idle_in();
    issue(4, 3, 0, 0, 1, 2);
    res_valid = 1; res_tag = 0; res_data = 'h3c; #1;
    chk("R9", "superseded result not written", int'(wb_valid), 0);
    step(); idle_in();

    // R2: fill the pool, then an ignored issue
    ph = "R2";
    for (int n = 0; n < 8; n++) begin
      if (iss_ready) begin issue(5, n % NREG, (n + 1) % NREG, 2, n, n + 1); step(); idle_in(); end
    end
    chk("R2", "full pool stalls", int'(iss_ready), 0);
    issue(9, 1, 1, 1, 'hbad, 'hbad); step(); idle_in();

    // R10: random traffic with reuse of stations
    ph = "R10";
    for (int c = 0; c < 4000; c++) begin
      int cnt, pick;
      idle_in();
      if ($urandom_range(0, 1) == 1)
        issue($urandom_range(0, 15), $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
              $urandom_range(0, NREG - 1), $urandom_range(0, 65535), $urandom_range(0, 65535));
      disp_grant = ($urandom_range(0, 1) == 1);
      cnt = 0;
      for (int i = 0; i < NRS; i++) if (m_busy[i] && m_exec[i]) cnt++;
      if (cnt > 0 && $urandom_range(0, 9) < 6) begin
        pick = $urandom_range(0, cnt - 1);
        for (int i = 0; i < NRS; i++) if (m_busy[i] && m_exec[i]) begin
          if (pick == 0) begin res_valid = 1; res_tag = TW'(i); res_data = DW'($urandom_range(0, 65535)); end
          pick--;
        end
      end
      step();
    end
    idle_in();
    summary();
  end
endmodule